// File: doc/BRIEF.md
# Three-Wire Serial Configuration Bus

This block receives configuration words over a slow serial link made of a shift clock, a data line and an active-low select line. While select is low, each rising edge of the shift clock moves one data bit, most significant first, into a shift register. When select returns high, the last bit shifted in acts as an address. A 1 stores the 23 bits before it in the primary register, and a 0 stores the 8 bits before it in the secondary register. Any bits shifted in before a word fall off the top of the shift register. The number of clock pulses in a transfer is never counted or checked.

The stored fields drive registered outputs for the synthesiser and transmit blocks around it. These outputs are divider values, polarity bits, enable bits, a pretune code, a test code and three current scaling percentages. All three serial pins pass through synchronisers into the system clock domain. The power-up and hold inputs are taken as already synchronous to that clock. While powered down with hold low, both registers are held at their default contents. With hold high, they keep what was written.

Top module: `cfg3w_bus`

## Requirements
- R1: After synchronous reset the outputs show the defaults: all enables and polarities 0, `ref_div`=32, `main_div`=31, `swallow`=0, `prog_div`=992, all three percentages 100, `dac_code`=0, `test_code`=0.
- R2: Bits are sampled only on rising edges of `bus_sck` while `bus_sel_n` is low. Clock and data activity while `bus_sel_n` is high leaves every output unchanged.
- R3: A rise of `bus_sel_n` loads exactly one register, chosen by the last bit shifted in (1 primary, 0 secondary), and leaves the other register's outputs unchanged.
- R4: Bits shifted in ahead of a word are discarded: a primary word preceded by extra bits, or a secondary word preceded by extra bits, yields the same outputs as the bare word.
- R5: Primary bits [23:22] are a reference code: 0 gives `ref_div` 32, 1 gives 12, 2 gives 16, 3 gives 24.
- R6: Primary bits [16:15] are a main code giving `main_div` = 31 + code. Primary bits [21:17] are `swallow`. `prog_div` = 32 × `main_div` + `swallow`.
- R7: Each 3-bit scaling code c gives a percentage of 60 + 10·c: primary [9:7] to `flt_pct`, primary [3:1] to `pump_pct`, secondary [6:4] to `comp_pct`.
- R8: Primary bit 14 drives `flt_pol`, 13 drives `comp_pol`, 12 drives `pump_pol`, 11 drives `flt_en`, 10 drives `comp_en`, and [6:4] drives `dac_code`. Secondary bit 8 drives `dbl_en`, 7 drives `amp_en`, and [3:1] drives `test_code`.
- R9: With `pwr_up` low and `hold_en` low, both registers return to their defaults and stay there. With `pwr_up` low and `hold_en` high, the contents are kept.
- R10: The outputs change only after a register load, a loss of contents, or a reset.

Bit numbers count back from the address bit, which is bit 0 and is shifted in last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sck | input | 1 | Serial shift clock (asynchronous) |
| bus_sdi | input | 1 | Serial data, MSB first (asynchronous) |
| bus_sel_n | input | 1 | Active-low transfer select (asynchronous) |
| pwr_up | input | 1 | 1 = powered, 0 = power-down |
| hold_en | input | 1 | Keep register contents during power-down |
| ref_div | output | 6 | Reference divide ratio |
| main_div | output | 6 | Main counter ratio |
| swallow | output | 5 | Swallow count |
| prog_div | output | 11 | Total programmable divide ratio |
| flt_pol | output | 1 | Filter output polarity |
| comp_pol | output | 1 | Compensation data polarity |
| pump_pol | output | 1 | Charge-pump polarity |
| flt_en | output | 1 | Filter enable |
| comp_en | output | 1 | Compensation enable |
| flt_pct | output | 8 | Filter current, percent |
| pump_pct | output | 8 | Pump current, percent |
| dac_code | output | 3 | Pretune DAC code |
| dbl_en | output | 1 | Doubler enable |
| amp_en | output | 1 | Amplifier enable |
| comp_pct | output | 8 | Compensation current, percent |
| test_code | output | 3 | Test mode code |

## Verification
The divider fields are swept over every main code and every swallow value, with the reference code varied along the way. Any shift misalignment or decode slip then shows up as a wrong sum in `prog_div`. A second sweep runs all eight scaling codes through both words, using different codes per field, which separates swapped fields from wrong arithmetic. Padded words show whether leading bits leak into the fields. Alternating loads of the two words show whether the address bit picks the right register. Clock toggles with select high, and the two power-down modes, show whether contents change only when they should.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int W1_BITS = 23;
  localparam int W2_BITS = 8;
  localparam int PCT_W   = 8;
  localparam int DIV_W   = 6;
  localparam int SW_W    = 5;
  localparam int PROG_W  = DIV_W + SW_W;

  typedef struct packed {
    logic [1:0] ref_code;
    logic [4:0] swal;
    logic [1:0] main_code;
    logic       flt_pol;
    logic       comp_pol;
    logic       pump_pol;
    logic       flt_en;
    logic       comp_en;
    logic [2:0] flt_scl;
    logic [2:0] dac_code;
    logic [2:0] pump_scl;
  } word1_t;

  typedef struct packed {
    logic       dbl_en;
    logic       amp_en;
    logic [2:0] comp_scl;
    logic [2:0] test_code;
  } word2_t;

  localparam word1_t W1_DEFAULT = '{ref_code: 2'd0, swal: 5'd0, main_code: 2'd0,
                                    flt_pol: 1'b0, comp_pol: 1'b0, pump_pol: 1'b0,
                                    flt_en: 1'b0, comp_en: 1'b0, flt_scl: 3'd4,
                                    dac_code: 3'd0, pump_scl: 3'd4};
  localparam word2_t W2_DEFAULT = '{dbl_en: 1'b0, amp_en: 1'b0,
                                    comp_scl: 3'd4, test_code: 3'd0};

  function automatic logic [PCT_W-1:0] scale_pct(input logic [2:0] c);
    return PCT_W'(60 + 10 * int'(c));
  endfunction

  function automatic logic [DIV_W-1:0] ref_ratio(input logic [1:0] c);
    case (c)
      2'd1:    return DIV_W'(12);
      2'd2:    return DIV_W'(16);
      2'd3:    return DIV_W'(24);
      default: return DIV_W'(32);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] main_ratio(input logic [1:0] c);
    return DIV_W'(31 + int'(c));
  endfunction
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
  parameter int SR_W = 24,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sck,
  input  logic            sdi,
  input  logic            sel_n,
  output logic [SR_W-1:0] sr,
  output logic            load_stb
);
  logic [2:0] pins_s;
  logic sel_s, sck_s, sdi_s, sck_d, sel_d;

  cfg3w_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({sel_n, sck, sdi}), .q(pins_s)
  );
  assign {sel_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      sel_d <= 1'b1;
      sr    <= '0;
    end else begin
      sck_d <= sck_s;
      sel_d <= sel_s;
      if (sck_s && !sck_d && !sel_s) sr <= {sr[SR_W-2:0], sdi_s};
    end
  end

  assign load_stb = sel_s && !sel_d;
endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
  import cfg3w_pkg::*;
#(
  parameter int SR_W = W1_BITS + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lose,
  input  logic            load,
  input  logic [SR_W-1:0] sr,
  output word1_t          w1,
  output word2_t          w2
);
  always_ff @(posedge clk) begin
    if (rst || lose) begin
      w1 <= W1_DEFAULT;
      w2 <= W2_DEFAULT;
    end else if (load) begin
      if (sr[0]) w1 <= word1_t'(sr[W1_BITS:1]);
      else       w2 <= word2_t'(sr[W2_BITS:1]);
    end
  end
endmodule

// File: rtl/cfg3w_decode.sv
module cfg3w_decode
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  word1_t            w1,
  input  word2_t            w2,
  output logic [DIV_W-1:0]  ref_div,
  output logic [DIV_W-1:0]  main_div,
  output logic [SW_W-1:0]   swallow,
  output logic [PROG_W-1:0] prog_div,
  output logic              flt_pol,
  output logic              comp_pol,
  output logic              pump_pol,
  output logic              flt_en,
  output logic              comp_en,
  output logic [PCT_W-1:0]  flt_pct,
  output logic [PCT_W-1:0]  pump_pct,
  output logic [2:0]        dac_code,
  output logic              dbl_en,
  output logic              amp_en,
  output logic [PCT_W-1:0]  comp_pct,
  output logic [2:0]        test_code
);
  word1_t a;
  word2_t b;
  logic [DIV_W-1:0] main_n;

  assign a = rst ? W1_DEFAULT : w1;
  assign b = rst ? W2_DEFAULT : w2;
  assign main_n = main_ratio(a.main_code);

  always_ff @(posedge clk) begin
    ref_div   <= ref_ratio(a.ref_code);
    main_div  <= main_n;
    swallow   <= a.swal;
    prog_div  <= {main_n, {SW_W{1'b0}}} + PROG_W'(a.swal);
    flt_pol   <= a.flt_pol;
    comp_pol  <= a.comp_pol;
    pump_pol  <= a.pump_pol;
    flt_en    <= a.flt_en;
    comp_en   <= a.comp_en;
    flt_pct   <= scale_pct(a.flt_scl);
    pump_pct  <= scale_pct(a.pump_scl);
    dac_code  <= a.dac_code;
    dbl_en    <= b.dbl_en;
    amp_en    <= b.amp_en;
    comp_pct  <= scale_pct(b.comp_scl);
    test_code <= b.test_code;
  end
endmodule

// File: rtl/cfg3w_bus.sv
module cfg3w_bus
  import cfg3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sck,
  input  logic              bus_sdi,
  input  logic              bus_sel_n,
  input  logic              pwr_up,
  input  logic              hold_en,
  output logic [DIV_W-1:0]  ref_div,
  output logic [DIV_W-1:0]  main_div,
  output logic [SW_W-1:0]   swallow,
  output logic [PROG_W-1:0] prog_div,
  output logic              flt_pol,
  output logic              comp_pol,
  output logic              pump_pol,
  output logic              flt_en,
  output logic              comp_en,
  output logic [PCT_W-1:0]  flt_pct,
  output logic [PCT_W-1:0]  pump_pct,
  output logic [2:0]        dac_code,
  output logic              dbl_en,
  output logic              amp_en,
  output logic [PCT_W-1:0]  comp_pct,
  output logic [2:0]        test_code
);
  localparam int SR_W = W1_BITS + 1;

  logic [SR_W-1:0] sr;
  logic load_stb, lose_now;
  word1_t w1;
  word2_t w2;

  assign lose_now = !pwr_up && !hold_en;

  cfg3w_shift #(.SR_W(SR_W), .STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst(rst), .sck(bus_sck), .sdi(bus_sdi), .sel_n(bus_sel_n),
    .sr(sr), .load_stb(load_stb)
  );

  cfg3w_regs #(.SR_W(SR_W)) u_regs (
    .clk(clk), .rst(rst), .lose(lose_now), .load(load_stb), .sr(sr),
    .w1(w1), .w2(w2)
  );

  cfg3w_decode u_dec (
    .clk(clk), .rst(rst), .w1(w1), .w2(w2),
    .ref_div(ref_div), .main_div(main_div), .swallow(swallow), .prog_div(prog_div),
    .flt_pol(flt_pol), .comp_pol(comp_pol), .pump_pol(pump_pol),
    .flt_en(flt_en), .comp_en(comp_en), .flt_pct(flt_pct), .pump_pct(pump_pct),
    .dac_code(dac_code), .dbl_en(dbl_en), .amp_en(amp_en),
    .comp_pct(comp_pct), .test_code(test_code)
  );
endmodule

// File: rtl/cfg3w_bus_chk.sv
module cfg3w_bus_chk (
  input logic       clk,
  input logic       rst,
  input logic       load_stb,
  input logic       lose_now,
  input logic [5:0] ref_div,
  input logic [5:0] main_div,
  input logic [4:0] swallow,
  input logic [10:0] prog_div,
  input logic       flt_en,
  input logic       comp_en,
  input logic       dbl_en,
  input logic       amp_en,
  input logic [7:0] flt_pct,
  input logic [7:0] pump_pct,
  input logic [7:0] comp_pct,
  input logic [2:0] test_code
);
  logic rst_q, ld_q, lost_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      ld_q   <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      ld_q   <= load_stb;
      lost_q <= lose_now;
    end
  end

  // R1
  reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!flt_en && !comp_en && !dbl_en && !amp_en && ref_div == 6'd32 &&
               main_div == 6'd31 && flt_pct == 8'd100 && comp_pct == 8'd100 &&
               test_code == 3'd0));

  // R3
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

  // R6
  main_range_chk: assert property (@(posedge clk) disable iff (rst)
    (main_div >= 6'd31 && main_div <= 6'd34 &&
     prog_div == {main_div, 5'b0} + 11'(swallow)));

  // R7
  pct_range_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_pct >= 8'd60 && flt_pct <= 8'd130 && pump_pct >= 8'd60 &&
     pump_pct <= 8'd130 && comp_pct % 8'd10 == 8'd0));

  // R9
  lost_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    (lost_q && lose_now) |=> (!dbl_en && !amp_en && !flt_en && comp_pct == 8'd100));

  // R10
  quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_q && !lost_q) |=> $stable({ref_div, main_div, swallow, flt_en, comp_en,
                                    dbl_en, amp_en, flt_pct, pump_pct, comp_pct,
                                    test_code}));
endmodule

bind cfg3w_bus cfg3w_bus_chk u_chk (
  .clk(clk), .rst(rst), .load_stb(load_stb), .lose_now(lose_now),
  .ref_div(ref_div), .main_div(main_div), .swallow(swallow), .prog_div(prog_div),
  .flt_en(flt_en), .comp_en(comp_en), .dbl_en(dbl_en), .amp_en(amp_en),
  .flt_pct(flt_pct), .pump_pct(pump_pct), .comp_pct(comp_pct), .test_code(test_code)
);

// File: tb/cfg3w_bus_tb.sv
module cfg3w_bus_tb;
  localparam int HALF = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, sdi = 1'b0, sel_n = 1'b1, pwr_up = 1'b1, hold_en = 1'b1;
  logic [5:0] ref_div, main_div;
  logic [4:0] swallow;
  logic [10:0] prog_div;
  logic flt_pol, comp_pol, pump_pol, flt_en, comp_en, dbl_en, amp_en;
  logic [7:0] flt_pct, pump_pct, comp_pct;
  logic [2:0] dac_code, test_code;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg3w_bus u_dut (
    .clk(clk), .rst(rst), .bus_sck(sck), .bus_sdi(sdi), .bus_sel_n(sel_n),
    .pwr_up(pwr_up), .hold_en(hold_en), .ref_div(ref_div), .main_div(main_div),
    .swallow(swallow), .prog_div(prog_div), .flt_pol(flt_pol), .comp_pol(comp_pol),
    .pump_pol(pump_pol), .flt_en(flt_en), .comp_en(comp_en), .flt_pct(flt_pct),
    .pump_pct(pump_pct), .dac_code(dac_code), .dbl_en(dbl_en), .amp_en(amp_en),
    .comp_pct(comp_pct), .test_code(test_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk1(input int rc, sw, mc, pol, en, gs, dc, ps);
    return {8'd0, rc[1:0], sw[4:0], mc[1:0], pol[2:0], en[1:0], gs[2:0], dc[2:0], ps[2:0], 1'b1};
  endfunction

  function automatic logic [31:0] mk2(input int dbl, amp, cs, tc);
    return {23'd0, dbl[0], amp[0], cs[2:0], tc[2:0], 1'b0};
  endfunction

  function automatic int exp_ref(input int c);
    case (c)
      1: return 12;
      2: return 16;
      3: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic send(input logic [31:0] v, input int n);
    @(negedge clk) sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flt_en", flt_en, 0);
    chk("R1 dbl_en", dbl_en, 0);
    chk("R1 ref_div", ref_div, 32);
    chk("R1 main_div", main_div, 31);
    chk("R1 prog_div", prog_div, 992);
    chk("R1 flt_pct", flt_pct, 100);
    chk("R1 pump_pct", pump_pct, 100);
    chk("R1 comp_pct", comp_pct, 100);
    chk("R1 test_code", test_code, 0);

    // R5 R6 divider sweep
    for (int mc = 0; mc < 4; mc++) begin
      for (int sw = 0; sw < 32; sw++) begin
        send(mk1(sw % 4, sw, mc, 0, 0, 4, 0, 4), 24);
        chk("R5 ref_div", ref_div, exp_ref(sw % 4));
        chk("R6 main_div", main_div, 31 + mc);
        chk("R6 swallow", swallow, sw);
        chk("R6 prog_div", prog_div, 32 * (31 + mc) + sw);
      end
    end

    // R7 R8 scaling and bit sweep
    for (int c = 0; c < 8; c++) begin
      send(mk1(0, 0, 0, c, c % 4, c, 7 - c, (c + 3) % 8), 24);
      send(mk2(c % 2, c / 4, (c + 5) % 8, c), 9);
      chk("R7 flt_pct", flt_pct, 60 + 10 * c);
      chk("R7 pump_pct", pump_pct, 60 + 10 * ((c + 3) % 8));
      chk("R7 comp_pct", comp_pct, 60 + 10 * ((c + 5) % 8));
      chk("R8 pols", {flt_pol, comp_pol, pump_pol}, c);
      chk("R8 enables", {flt_en, comp_en}, c % 4);
      chk("R8 dac_code", dac_code, 7 - c);
      chk("R8 dbl_en", dbl_en, c % 2);
      chk("R8 amp_en", amp_en, c / 4);
      chk("R8 test_code", test_code, c);
    end

    // R3 address selection, other register untouched
    send(mk2(1, 1, 2, 6), 9);
    send(mk1(3, 7, 2, 5, 3, 1, 2, 6), 24);
    chk("R3 w2 kept comp_pct", comp_pct, 80);
    chk("R3 w2 kept test_code", test_code, 6);
    chk("R3 w1 loaded flt_pct", flt_pct, 70);
    send(mk2(0, 0, 7, 3), 9);
    chk("R3 w1 kept flt_pct", flt_pct, 70);
    chk("R3 w1 kept prog_div", prog_div, 32 * 33 + 7);
    chk("R3 w2 loaded comp_pct", comp_pct, 130);

    // R4 leading bits discarded
    send(mk2(1, 0, 6, 5) | 32'h0000_7E00, 15);
    chk("R4 w2 comp_pct", comp_pct, 120);
    chk("R4 w2 test_code", test_code, 5);
    chk("R4 w2 dbl_en", dbl_en, 1);
    chk("R4 w1 untouched", flt_pct, 70);
    send(mk1(2, 19, 1, 2, 1, 5, 4, 0) | 32'h0F00_0000, 28);
    chk("R4 w1 ref_div", ref_div, 16);
    chk("R4 w1 prog_div", prog_div, 32 * 32 + 19);
    chk("R4 w1 pump_pct", pump_pct, 60);
    chk("R4 w1 flt_pct", flt_pct, 110);

    // R2 R10 activity with select high
    for (int k = 0; k < 10; k++) begin
      @(negedge clk) sdi = k[0];
      repeat (HALF) @(negedge clk) sck = 1'b1;
      repeat (HALF) @(negedge clk) sck = 1'b0;
    end
    repeat (12) @(negedge clk);
    chk("R2 R10 prog_div", prog_div, 32 * 32 + 19);
    chk("R2 R10 comp_pct", comp_pct, 120);
    chk("R2 R10 flt_pct", flt_pct, 110);

    // R9 power-down with hold
    pwr_up = 1'b0; hold_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 hold prog_div", prog_div, 32 * 32 + 19);
    chk("R9 hold comp_pct", comp_pct, 120);
    pwr_up = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 hold dbl_en", dbl_en, 1);
    pwr_up = 1'b0; hold_en = 1'b0;
    repeat (5) @(negedge clk);
    pwr_up = 1'b1; hold_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 lost prog_div", prog_div, 992);
    chk("R9 lost comp_pct", comp_pct, 100);
    chk("R9 lost flt_pct", flt_pct, 100);
    chk("R9 lost dbl_en", dbl_en, 0);
    chk("R9 lost test_code", test_code, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule